// File: doc/BRIEF.md
# Multi-Modulus Triple Generator

This block produces the "three times" multiple of an n-bit residue, the one odd multiple that a radix-8 signed-digit multiplier cannot get by shifting alone. A two-bit select chooses at run time which of three related moduli the result is reduced by. The moduli are 2^n-1 (plain binary with two codes for zero), 2^n (plain binary), and 2^n+1 (diminished-by-one coding, where code k stands for the value k+1). The same carry network serves all three moduli. Only the wrap-around bit of the doubled operand and the carry fed back into bit 0 change with the select.

The block is a dedicated adder of X and its doubled form. The second addend is X shifted up by one place, so per-bit generate and propagate come straight from neighbouring operand bits: an AND gives generate and an OR gives propagate. A parallel-prefix tree turns them into group carries. A late carry-in then applies the modulus-specific feedback. The block holds no state. The result follows the inputs combinationally.

Top module: `mm_hard_multiple`

## Requirements
- R1: With select 2'b01 the output equals (3*X) mod 2^n.
- R2: With select 2'b10 the output is congruent to 3*X modulo 2^n-1. The all-ones code is accepted as a second zero.
- R3: With select 2'b10 the all-zeros output code appears only for X equal to zero.
- R4: With select 2'b00, the input is read as diminished-by-one, so code X stands for X+1. The output is then the diminished-by-one code of 3*(X+1) mod (2^n+1), that is (3*(X+1) mod (2^n+1)) - 1.
- R5: With select 2'b00 the boundary codes map as follows: X=0 gives 2 and X=2^n-1 gives 2^n-3.
- R6: Select code 2'b11 behaves exactly like 2'b01.
- R7: With select 2'b01 or 2'b11, output bit 0 equals X bit 0 and output bit 1 equals X[1] XOR X[0].
- R8: The block is combinational. A new input settles at the output within the same clock period, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | N | Operand residue (diminished-by-one when select is 2'b00) |
| mod_sel_i | input | 2 | Modulus select: 00 = 2^n+1, 01 = 2^n, 10 = 2^n-1, 11 = same as 01 |
| h3x_o | output | N | Reduced triple of the operand |

## Verification
The block has no state, so any fault in the wrap-bit selector, the prefix tree or the carry feedback shows up at once. It appears in the output for the very operand that exercises it, in the same cycle. A wrong wrap bit damages bit 0 of the sum. A wrong feedback carry changes every result of one modulus whose sum overflows. A broken prefix node corrupts only operands whose carry chain crosses that node. Because of that last case, the bench sweeps every operand under every select code.

// File: rtl/mm_hard_multiple_pkg.sv
package mm_hard_multiple_pkg;

  typedef enum logic [1:0] {
    MOD_DIM1 = 2'b00,  // 2^n+1, diminished-by-one coding
    MOD_POW2 = 2'b01,  // 2^n, carry discarded
    MOD_ONES = 2'b10,  // 2^n-1, carry wrapped
    MOD_RSVD = 2'b11   // treated as MOD_POW2
  } mod_sel_e;

  // Group generate of a combined span: upper span (gh,ph) over lower span gl.
  function automatic logic gp_gen(input logic gh, input logic ph, input logic gl);
    return gh | (ph & gl);
  endfunction

endpackage

// File: rtl/mm_hm_pre.sv
module mm_hm_pre
  import mm_hard_multiple_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x_i,
  input  mod_sel_e     mode_i,
  output logic [N-1:0] gen_o,
  output logic [N-1:0] prp_o,
  output logic [N-1:0] hsum_o
);

  logic          wrap_bit;
  logic [N-1:0]  dbl;

  // Bit shifted into position 0 of the doubled operand.
  always_comb begin
    unique case (mode_i)
      MOD_ONES: wrap_bit = x_i[N-1];
      MOD_DIM1: wrap_bit = ~x_i[N-1];
      default:  wrap_bit = 1'b0;
    endcase
  end

  assign dbl = {x_i[N-2:0], wrap_bit};

  // Neighbouring-bit correlation: addend bits are x[i] and x[i-1].
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      assign gen_o[gi]  = x_i[gi] & dbl[gi];
      assign prp_o[gi]  = x_i[gi] | dbl[gi];
      assign hsum_o[gi] = x_i[gi] ^ dbl[gi];
    end
  endgenerate

endmodule

// File: rtl/mm_hm_prefix.sv
module mm_hm_prefix
  import mm_hard_multiple_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prp_i,
  output logic [N-1:0] grp_g_o,
  output logic [N-1:0] grp_p_o
);

  localparam int LV = $clog2(N);

  logic [LV:0][N-1:0] g_lv;
  logic [LV:0][N-1:0] p_lv;

  assign g_lv[0] = gen_i;
  assign p_lv[0] = prp_i;

  genvar lv, bi;
  generate
    for (lv = 0; lv < LV; lv++) begin : g_level
      localparam int D = 1 << lv;
      for (bi = 0; bi < N; bi++) begin : g_node
        if (bi >= D) begin : g_comb
          assign g_lv[lv+1][bi] = gp_gen(g_lv[lv][bi], p_lv[lv][bi], g_lv[lv][bi-D]);
          assign p_lv[lv+1][bi] = p_lv[lv][bi] & p_lv[lv][bi-D];
        end else begin : g_pass
          assign g_lv[lv+1][bi] = g_lv[lv][bi];
          assign p_lv[lv+1][bi] = p_lv[lv][bi];
        end
      end
    end
  endgenerate

  assign grp_g_o = g_lv[LV];
  assign grp_p_o = p_lv[LV];

endmodule

// File: rtl/mm_hm_post.sv
module mm_hm_post
  import mm_hard_multiple_pkg::*;
#(
  parameter int N = 8
) (
  input  mod_sel_e     mode_i,
  input  logic [N-1:0] hsum_i,
  input  logic [N-1:0] grp_g_i,
  input  logic [N-1:0] grp_p_i,
  output logic [N-1:0] sum_o
);

  logic          cin;
  logic [N-1:0]  carry;

  // Carry fed back into bit 0: wrapped, dropped or complemented.
  always_comb begin
    unique case (mode_i)
      MOD_ONES: cin = grp_g_i[N-1];
      MOD_DIM1: cin = ~grp_g_i[N-1];
      default:  cin = 1'b0;
    endcase
  end

  assign carry[0] = cin;

  genvar ci;
  generate
    for (ci = 1; ci < N; ci++) begin : g_carry
      assign carry[ci] = gp_gen(grp_g_i[ci-1], grp_p_i[ci-1], cin);
    end
  endgenerate

  assign sum_o = hsum_i ^ carry;

  // R2: every position propagates and none generates, so the sum is the all-ones zero code.
  always_comb begin
    if (mode_i == MOD_ONES && grp_p_i[N-1] && !grp_g_i[N-1])
      a_r2_full_propagate: assert (sum_o == {N{1'b1}});
  end

endmodule

// File: rtl/mm_hard_multiple.sv
module mm_hard_multiple
  import mm_hard_multiple_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x_i,
  input  logic [1:0]   mod_sel_i,
  output logic [N-1:0] h3x_o
);

  mod_sel_e      mode;
  logic [N-1:0]  gen, prp, hsum;
  logic [N-1:0]  grp_g, grp_p;

  assign mode = mod_sel_e'(mod_sel_i);

  mm_hm_pre #(.N(N)) u_pre (
    .x_i    (x_i),
    .mode_i (mode),
    .gen_o  (gen),
    .prp_o  (prp),
    .hsum_o (hsum)
  );

  mm_hm_prefix #(.N(N)) u_prefix (
    .gen_i   (gen),
    .prp_i   (prp),
    .grp_g_o (grp_g),
    .grp_p_o (grp_p)
  );

  mm_hm_post #(.N(N)) u_post (
    .mode_i  (mode),
    .hsum_i  (hsum),
    .grp_g_i (grp_g),
    .grp_p_i (grp_p),
    .sum_o   (h3x_o)
  );

  always_comb begin
    if (mode == MOD_POW2 || mode == MOD_RSVD) begin
      a_r7_low_bits: assert (h3x_o[0] == x_i[0] && h3x_o[1] == (x_i[1] ^ x_i[0]));
    end
    if (mode == MOD_ONES && h3x_o == '0) begin
      a_r3_zero_only_from_zero: assert (x_i == '0);
    end
    if (mode == MOD_DIM1 && x_i == '0) begin
      a_r5_dim1_low_end: assert (h3x_o == N'(2));
    end
    if (mode == MOD_DIM1 && x_i == {N{1'b1}}) begin
      a_r5_dim1_high_end: assert (h3x_o == {N{1'b1}} - N'(2));
    end
  end

endmodule

// File: tb/mm_hard_multiple_tb.sv
module mm_hard_multiple_tb;

  localparam int N = 8;
  localparam int M = 1 << N;

  logic         clk;
  logic [N-1:0] x;
  logic [1:0]   sel;
  logic [N-1:0] h3x;
  int           checks;
  int           errors;
  bit           done;

  mm_hard_multiple #(.N(N)) u_dut (
    .x_i       (x),
    .mod_sel_i (sel),
    .h3x_o     (h3x)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input int act, input int exp, input int xv, input int sv);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: sel=%0d x=%0d actual=%0d expected=%0d", req, sv, xv, act, exp);
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    x      = '0;
    sel    = 2'b01;
    @(negedge clk);
    #5;
    // Initial state: X=0 under 2^n gives 0 (R1)
    check("R1", int'(h3x), 0, 0, 1);

    for (int s = 0; s < 4; s++) begin
      for (int xv = 0; xv < M; xv++) begin
        @(negedge clk);
        sel = 2'(s);
        x   = N'(xv);
        #5;
        case (s)
          1: begin
            check("R1", int'(h3x), (3 * xv) % M, xv, s);
            check("R7", int'(h3x[1:0]), ((xv & 1) | ((((xv >> 1) ^ xv) & 1) << 1)), xv, s);
          end
          3: begin
            check("R6", int'(h3x), (3 * xv) % M, xv, s);
            check("R7", int'(h3x[1:0]), ((xv & 1) | ((((xv >> 1) ^ xv) & 1) << 1)), xv, s);
          end
          2: begin
            int e;
            int a;
            e = (3 * xv) % (M - 1);
            a = int'(h3x);
            if (e == 0 && a == M - 1) a = 0;
            check("R2", a, e, xv, s);
            check("R3", int'(h3x == '0), int'(xv == 0), xv, s);
          end
          default: begin
            check("R4", int'(h3x), ((3 * (xv + 1)) % (M + 1)) - 1, xv, s);
            if (xv == 0)     check("R5", int'(h3x), 2, xv, s);
            if (xv == M - 1) check("R5", int'(h3x), M - 3, xv, s);
          end
        endcase
      end
    end

    // R8: change inputs with no clock edge in between; output must follow.
    @(posedge clk);
    #3;
    sel = 2'b01;
    x   = N'(5);
    #2;
    check("R8", int'(h3x), 15, 5, 1);
    x = N'(100);
    #2;
    check("R8", int'(h3x), 300 % M, 100, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule